// File: doc/BRIEF.md
# Two-Wire Command Front-End for a Quad Digital Potentiometer

This block is the serial slave interface of a four-channel digital potentiometer controller. It runs on a fast system clock and oversamples the two bus lines. It finds start and stop conditions, checks the slave address byte against a fixed device-type code and four strapped address pins, and drives the acknowledge bit when the address matches. It then takes in an instruction byte, splits that byte into opcode, register select and pot select, and handles the rest of the command according to its class.

There are three command classes. A short command ends with its instruction byte. A data command needs one more byte, which the master writes or the block returns from an external read port. The step command gives the bus to an external wiper stepper. Commands that write nonvolatile storage are only reported when the closing stop condition arrives, and the nonvolatile cycle starts at that point. While the external nonvolatile write is still busy, the block gives no acknowledge to its own address, so a master can poll until the write is done. The register storage and the wiper movement are separate blocks, driven by the strobes that this block produces.

Top module: `potcmd_frontend`

## Requirements
- R1: While reset is held and in the first cycle after it, `sda_oe_o`, `cmd_valid_o`, `nv_start_o` and `incdec_o` are all low.
- R2: The slave address byte is eight bits, sent MSB first. The block acknowledges it (drives SDA low in the ninth clock) only when bits 7:4 equal 0101 and bits 3:0 equal `dev_addr_i`. On any mismatch it gives no acknowledge and ignores every later byte until the next start.
- R3: If `nv_busy_i` is high when the address byte ends, the address is not acknowledged. If it is low, a matching address is acknowledged.
- R4: The instruction byte carries the opcode in bits 7:4, the register select in bits 3:2 and the pot select in bits 1:0. These appear on `cmd_op_o`, `cmd_reg_o` and `cmd_pot_o` with every command strobe.
- R5: Only nine opcodes are accepted: 0x1, 0x2, 0x8, 0x9, 0xA, 0xB, 0xC, 0xD and 0xE. Any other opcode is not acknowledged and gives no strobe.
- R6: Opcodes 0xD and 0x1 (register-to-wiper transfers) give a one-cycle `cmd_valid_o` when the instruction acknowledge clock ends.
- R7: Opcodes 0xE and 0x8 (wiper-to-register nonvolatile transfers) give no strobe before the stop. At the stop, `cmd_valid_o` and `nv_start_o` pulse together.
- R8: Opcode 0xA (wiper write) acknowledges a third byte. It then gives `cmd_valid_o` with `cmd_data_o` equal to that byte when the data acknowledge clock ends.
- R9: Opcode 0xC (register write) acknowledges a third byte. It gives `cmd_valid_o` and `nv_start_o` together at the stop, with `cmd_data_o` equal to the written byte.
- R10: Opcodes 0x9 and 0xB (reads) capture `rd_data_i` when the instruction acknowledge ends and shift it out MSB first on SDA. The block then releases SDA for the master's acknowledge bit and pulses `cmd_valid_o` when that bit's clock ends.
- R11: Opcode 0x2 (step) pulses `cmd_valid_o` and raises `incdec_o` when the instruction acknowledge ends. `incdec_o` stays high through any further SCL activity, the block does not drive SDA in that time, and `incdec_o` drops at the stop.
- R12: A stop or repeated start before a command is complete cancels it, with no strobe and no `nv_start_o`. This also applies to a repeated start that follows a complete nonvolatile command before its stop.
- R13: `cmd_valid_o` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| dev_addr_i | input | 4 | Strapped low nibble of the slave address |
| nv_busy_i | input | 1 | External nonvolatile write still in progress |
| rd_data_i | input | 8 | Register contents returned for read commands |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 4 | Opcode of the command |
| cmd_reg_o | output | 2 | Register select of the command |
| cmd_pot_o | output | 2 | Pot select of the command |
| cmd_data_o | output | 8 | Written byte, or the byte sent for a read |
| nv_start_o | output | 1 | Start the nonvolatile write cycle |
| incdec_o | output | 1 | Step mode active, bus handed to the wiper stepper |

## Verification
Each bus edge reaches the decision logic after the two synchronizer flops plus one edge-detect compare. The acknowledge drive, the read data bits and every strobe therefore change three to four system cycles after the SCL edge that causes them. The bench holds each SCL phase for eight cycles and samples SDA in the middle of the high phase, so a drive from the block is always settled when it is read. Strobes are counted on the falling system clock edge, and each count is compared eight cycles after the bus edge that ends a byte or a stop, after the latest point the pulse can appear.

// File: rtl/potcmd_pkg.sv
// Package: shared constants and types for the potentiometer command front-end.
// Assumes bytes are eight bits wide and opcodes four bits wide.
package potcmd_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [3:0] OP_STEP      = 4'h2;
    localparam logic [3:0] OP_GXFER     = 4'h1;
    localparam logic [3:0] OP_GSAVE     = 4'h8;
    localparam logic [3:0] OP_RD_WIPER  = 4'h9;
    localparam logic [3:0] OP_WR_WIPER  = 4'hA;
    localparam logic [3:0] OP_RD_REG    = 4'hB;
    localparam logic [3:0] OP_WR_REG    = 4'hC;
    localparam logic [3:0] OP_XFER      = 4'hD;
    localparam logic [3:0] OP_SAVE      = 4'hE;

    typedef enum logic [2:0] {
        CL_BAD,
        CL_XFER,
        CL_XFER_NV,
        CL_READ,
        CL_WRITE,
        CL_WRITE_NV,
        CL_STEP
    } cmd_class_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_INSTR,
        ST_IACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_DONE,
        ST_STEP,
        ST_IGNORE
    } bus_state_t;

endpackage

// File: rtl/potcmd_linesync.sv
// Module: synchronizes SCL and SDA into the system clock domain and flags
// SCL edges and start/stop conditions.
// Assumes the system clock runs several times faster than SCL and that both
// lines idle high. The outputs lag the pins by SYNC_STAGES+1 cycles.
module potcmd_linesync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_p;
    logic [SYNC_STAGES-1:0] sda_p;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage: capture the raw pin levels.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_p[0] <= 1'b1;
                    sda_p[0] <= 1'b1;
                end else begin
                    scl_p[0] <= scl_i;
                    sda_p[0] <= sda_i;
                end
            end
        end else begin : g_next
            // Later stages: pass the level one flop further.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_p[i] <= 1'b1;
                    sda_p[i] <= 1'b1;
                end else begin
                    scl_p[i] <= scl_p[i-1];
                    sda_p[i] <= sda_p[i-1];
                end
            end
        end
    end

    assign scl_s = scl_p[SYNC_STAGES-1];
    assign sda_s = sda_p[SYNC_STAGES-1];

    // Hold the previous synchronized levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and bus-condition flags from current versus previous level.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/potcmd_decode.sv
// Module: maps a four-bit opcode to its command class.
// Assumes nine legal opcodes. Every other code maps to CL_BAD.
module potcmd_decode
    import potcmd_pkg::*;
(
    input  logic [3:0]  op,
    output cmd_class_t  cls
);
    // Pure lookup of the class for each opcode.
    always_comb begin
        case (op)
            OP_XFER, OP_GXFER:       cls = CL_XFER;
            OP_SAVE, OP_GSAVE:       cls = CL_XFER_NV;
            OP_RD_WIPER, OP_RD_REG:  cls = CL_READ;
            OP_WR_WIPER:             cls = CL_WRITE;
            OP_WR_REG:               cls = CL_WRITE_NV;
            OP_STEP:                 cls = CL_STEP;
            default:                 cls = CL_BAD;
        endcase
    end

endmodule

// File: rtl/potcmd_frontend.sv
// Module: two-wire slave front-end that turns bus traffic into decoded
// potentiometer commands. It checks the address (and suppresses the
// acknowledge while a nonvolatile write is busy), decodes the instruction,
// moves a third data byte in either direction, and hands the bus to the
// stepper for step commands.
// Assumes an open-drain bus. sda_oe_o high means pull SDA low.
module potcmd_frontend
    import potcmd_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b0101
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [3:0]  dev_addr_i,
    input  logic        nv_busy_i,
    input  logic [7:0]  rd_data_i,
    output logic        cmd_valid_o,
    output logic [3:0]  cmd_op_o,
    output logic [1:0]  cmd_reg_o,
    output logic [1:0]  cmd_pot_o,
    output logic [7:0]  cmd_data_o,
    output logic        nv_start_o,
    output logic        incdec_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    bus_state_t        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic              ack_q, pend_q, valid_q, nvst_q;
    logic [3:0]        op_q;
    logic [1:0]        reg_q, pot_q;
    logic [BYTE_W-1:0] data_q;
    cmd_class_t        cls_q, sh_cls;
    logic              receiving, addr_ok;

    potcmd_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    potcmd_decode u_dec (
        .op  (sh_q[7:4]),
        .cls (sh_cls)
    );

    // States in which the block shifts in bits from the master.
    always_comb begin
        receiving = (st_q == ST_ADDR) || (st_q == ST_INSTR) || (st_q == ST_WDATA);
        addr_ok   = (sh_q[7:4] == DEV_CODE) && (sh_q[3:0] == dev_addr_i);
    end

    // Main bus sequencer: conditions first, then SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            ack_q   <= 1'b0;
            pend_q  <= 1'b0;
            valid_q <= 1'b0;
            nvst_q  <= 1'b0;
            op_q    <= '0;
            reg_q   <= '0;
            pot_q   <= '0;
            data_q  <= '0;
            cls_q   <= CL_BAD;
        end else begin
            valid_q <= 1'b0;
            nvst_q  <= 1'b0;
            if (start_det) begin
                st_q   <= ST_ADDR;
                cnt_q  <= '0;
                ack_q  <= 1'b0;
                pend_q <= 1'b0;
            end else if (stop_det) begin
                if (st_q == ST_DONE && pend_q) begin
                    valid_q <= 1'b1;
                    nvst_q  <= 1'b1;
                end
                st_q   <= ST_IDLE;
                ack_q  <= 1'b0;
                pend_q <= 1'b0;
            end else if (scl_rise) begin
                if (receiving) begin
                    sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end else if (scl_fall) begin
                case (st_q)
                    ST_ADDR: if (cnt_q == FULL_CNT) begin
                        cnt_q <= '0;
                        if (addr_ok && !nv_busy_i) begin
                            ack_q <= 1'b1;
                            st_q  <= ST_AACK;
                        end else begin
                            st_q  <= ST_IGNORE;
                        end
                    end
                    ST_AACK: begin
                        ack_q <= 1'b0;
                        st_q  <= ST_INSTR;
                    end
                    ST_INSTR: if (cnt_q == FULL_CNT) begin
                        cnt_q <= '0;
                        op_q  <= sh_q[7:4];
                        reg_q <= sh_q[3:2];
                        pot_q <= sh_q[1:0];
                        cls_q <= sh_cls;
                        if (sh_cls != CL_BAD) begin
                            ack_q <= 1'b1;
                            st_q  <= ST_IACK;
                        end else begin
                            st_q  <= ST_IGNORE;
                        end
                    end
                    ST_IACK: begin
                        ack_q <= 1'b0;
                        cnt_q <= '0;
                        case (cls_q)
                            CL_XFER: begin
                                valid_q <= 1'b1;
                                st_q    <= ST_DONE;
                            end
                            CL_XFER_NV: begin
                                pend_q <= 1'b1;
                                st_q   <= ST_DONE;
                            end
                            CL_READ: begin
                                sh_q   <= rd_data_i;
                                data_q <= rd_data_i;
                                st_q   <= ST_RDATA;
                            end
                            CL_WRITE, CL_WRITE_NV: st_q <= ST_WDATA;
                            CL_STEP: begin
                                valid_q <= 1'b1;
                                st_q    <= ST_STEP;
                            end
                            default: st_q <= ST_IGNORE;
                        endcase
                    end
                    ST_WDATA: if (cnt_q == FULL_CNT) begin
                        cnt_q  <= '0;
                        data_q <= sh_q;
                        ack_q  <= 1'b1;
                        st_q   <= ST_WACK;
                    end
                    ST_WACK: begin
                        ack_q <= 1'b0;
                        st_q  <= ST_DONE;
                        if (cls_q == CL_WRITE_NV) pend_q  <= 1'b1;
                        else                      valid_q <= 1'b1;
                    end
                    ST_RDATA: begin
                        if (cnt_q == LAST_TX) begin
                            cnt_q <= '0;
                            st_q  <= ST_RACK;
                        end else begin
                            sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    ST_RACK: begin
                        valid_q <= 1'b1;
                        st_q    <= ST_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output drive: acknowledge or the current read bit when it is zero.
    always_comb begin
        sda_oe_o    = ack_q | ((st_q == ST_RDATA) & ~sh_q[BYTE_W-1]);
        cmd_valid_o = valid_q;
        nv_start_o  = nvst_q;
        incdec_o    = (st_q == ST_STEP);
        cmd_op_o    = op_q;
        cmd_reg_o   = reg_q;
        cmd_pot_o   = pot_q;
        cmd_data_o  = data_q;
    end

endmodule

// File: rtl/potcmd_frontend_chk.sv
// Module: temporal checks on the command front-end, bound into every
// instance of potcmd_frontend. Assumes the package state encoding.
module potcmd_frontend_chk
    import potcmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       nv_busy_i,
    input logic       sda_oe_o,
    input logic       cmd_valid_o,
    input logic       nv_start_o,
    input logic       incdec_o,
    input logic [3:0] cmd_op_o,
    input bus_state_t st
);
    // R13
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    // R7
    nv_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nv_start_o |-> cmd_valid_o &&
            (cmd_op_o == OP_SAVE || cmd_op_o == OP_GSAVE || cmd_op_o == OP_WR_REG));

    // R5
    legal_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_op_o == OP_STEP || cmd_op_o == OP_GXFER ||
            cmd_op_o == OP_GSAVE || cmd_op_o[3:2] == 2'b10 ||
            cmd_op_o == OP_WR_REG || cmd_op_o == OP_XFER || cmd_op_o == OP_SAVE));

    // R11
    step_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(incdec_o) |-> cmd_valid_o && cmd_op_o == OP_STEP);

    // R11
    step_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        incdec_o |-> !sda_oe_o);

    // R3
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_AACK) |-> !$past(nv_busy_i));

endmodule

bind potcmd_frontend potcmd_frontend_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nv_busy_i   (nv_busy_i),
    .sda_oe_o    (sda_oe_o),
    .cmd_valid_o (cmd_valid_o),
    .nv_start_o  (nv_start_o),
    .incdec_o    (incdec_o),
    .cmd_op_o    (cmd_op_o),
    .st          (st_q)
);

// File: tb/potcmd_frontend_test.sv
`timescale 1ns/1ps
// Bench: drives bus transactions as a master, sweeps addresses and opcodes,
// and compares acknowledges, read bits and strobes with expected values.
module potcmd_frontend_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] dev_addr = 4'h0;
    logic       nv_busy = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       sda_oe, cmd_valid, nv_start, incdec;
    logic [3:0] cmd_op;
    logic [1:0] cmd_reg, cmd_pot;
    logic [7:0] cmd_data;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0, fails = 0;
    int n_valid = 0, n_nv = 0, n_double = 0;
    logic prev_valid = 1'b0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    potcmd_frontend uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .dev_addr_i(dev_addr), .nv_busy_i(nv_busy),
        .rd_data_i(rd_data), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
        .cmd_reg_o(cmd_reg), .cmd_pot_o(cmd_pot), .cmd_data_o(cmd_data),
        .nv_start_o(nv_start), .incdec_o(incdec)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) n_valid++;
            if (nv_start) n_nv++;
            if (cmd_valid && prev_valid) n_double++;
            prev_valid = cmd_valid;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        waitc(4); sda_m = 1'b1; waitc(4); scl_m = 1'b1; waitc(8);
        sda_m = 1'b0; waitc(8); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        waitc(4); sda_m = 1'b0; waitc(4); scl_m = 1'b1; waitc(8);
        sda_m = 1'b1; waitc(8);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        waitc(4); sda_m = b; waitc(4); scl_m = 1'b1; waitc(4);
        r = sda_line; waitc(4); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic read_byte(output logic [7:0] b, input logic master_ack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            b[i] = r;
        end
        bus_bit(~master_ack, r);
    endtask

    // Expected class: 0 bad, 1 transfer, 2 nv transfer, 3 read, 4 write, 5 nv write, 6 step
    function automatic int exp_class(input logic [3:0] op);
        case (op)
            4'hD, 4'h1: return 1;
            4'hE, 4'h8: return 2;
            4'h9, 4'hB: return 3;
            4'hA:       return 4;
            4'hC:       return 5;
            4'h2:       return 6;
            default:    return 0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic a, r;
        logic [7:0] rb, instr, dat;
        int v0, nv0, cls;

        waitc(3);
        // R1: outputs quiet during reset
        chk("R1 oe", sda_oe, 0); chk("R1 valid", cmd_valid, 0);
        chk("R1 nv", nv_start, 0); chk("R1 incdec", incdec, 0);
        rst_n = 1'b1;
        waitc(1);
        chk("R1 oe after", sda_oe, 0); chk("R1 valid after", cmd_valid, 0);
        waitc(10);

        // R2: address sweep over strap values and the whole low nibble
        for (int p = 0; p < 16; p += 5) begin
            dev_addr = 4'(p);
            for (int lo = 0; lo < 16; lo++) begin
                bus_start(); send_byte({4'b0101, 4'(lo)}, a); bus_stop();
                chk("R2 addr ack", a, (lo == p) ? 1 : 0);
            end
        end
        // R2: device-type nibble sweep with matching low nibble
        dev_addr = 4'hA;
        for (int hi = 0; hi < 16; hi++) begin
            bus_start(); send_byte({4'(hi), 4'hA}, a); bus_stop();
            chk("R2 type ack", a, (hi == 5) ? 1 : 0);
        end
        // R2: after a mismatch, following bytes are ignored until start
        v0 = n_valid;
        bus_start(); send_byte(8'h5B, a); send_byte(8'hD0, a); waitc(8);
        chk("R2 ignore ack", a, 0); chk("R2 ignore strobe", n_valid - v0, 0);
        bus_stop();

        // R3: busy suppresses the address acknowledge
        nv_busy = 1'b1;
        bus_start(); send_byte(8'h5A, a); bus_stop();
        chk("R3 busy nack", a, 0);
        nv_busy = 1'b0;
        bus_start(); send_byte(8'h5A, a); bus_stop();
        chk("R3 idle ack", a, 1);

        // R4..R11: opcode sweep
        for (int op = 0; op < 16; op++) begin
            cls   = exp_class(4'(op));
            instr = {4'(op), 2'(op + 1), 2'(op * 3)};
            dat   = 8'(op * 37 + 5);
            rd_data = 8'(op * 29 + 100);
            v0 = n_valid; nv0 = n_nv;
            bus_start(); send_byte(8'h5A, a);
            chk("R2 sweep addr", a, 1);
            send_byte(instr, a);
            chk("R5 instr ack", a, (cls != 0) ? 1 : 0);
            waitc(8);
            case (cls)
                0: chk("R5 no strobe", n_valid - v0, 0);
                1: begin
                    chk("R6 strobe", n_valid - v0, 1);
                    chk("R4 op", cmd_op, op);
                    chk("R4 reg", cmd_reg, instr[3:2]);
                    chk("R4 pot", cmd_pot, instr[1:0]);
                end
                2: chk("R7 no early strobe", n_valid - v0, 0);
                3: begin
                    read_byte(rb, 1'b0); waitc(8);
                    chk("R10 read bits", rb, rd_data);
                    chk("R10 strobe", n_valid - v0, 1);
                    chk("R10 data", cmd_data, rd_data);
                    chk("R4 read op", cmd_op, op);
                end
                4: begin
                    send_byte(dat, a); waitc(8);
                    chk("R8 data ack", a, 1);
                    chk("R8 strobe", n_valid - v0, 1);
                    chk("R8 data", cmd_data, dat);
                end
                5: begin
                    send_byte(dat, a); waitc(8);
                    chk("R9 data ack", a, 1);
                    chk("R9 no early strobe", n_valid - v0, 0);
                end
                6: begin
                    chk("R11 incdec high", incdec, 1);
                    chk("R11 strobe", n_valid - v0, 1);
                    chk("R4 step pot", cmd_pot, instr[1:0]);
                    bus_bit(1'b1, r); bus_bit(1'b0, r); bus_bit(1'b1, r);
                    chk("R11 sda free", r, 1);
                    chk("R11 incdec held", incdec, 1);
                end
                default: ;
            endcase
            bus_stop(); waitc(8);
            if (cls == 2 || cls == 5) begin
                chk("R7 stop strobe", n_valid - v0, 1);
                chk("R7 nv start", n_nv - nv0, 1);
                chk("R4 nv op", cmd_op, op);
                if (cls == 5) chk("R9 data", cmd_data, dat);
            end else begin
                chk("R7 no nv start", n_nv - nv0, 0);
            end
            if (cls == 6) chk("R11 incdec drop", incdec, 0);
        end

        // R12: aborts
        v0 = n_valid; nv0 = n_nv;
        bus_start(); send_byte(8'h5A, a); send_byte(8'hC5, a); send_byte(8'h3C, a);
        bus_start(); send_byte(8'h5A, a); bus_stop(); waitc(8);
        chk("R12 restart after write", n_nv - nv0, 0);
        bus_start(); send_byte(8'h5A, a); send_byte(8'hE1, a);
        bus_start(); bus_stop(); waitc(8);
        chk("R12 restart after save", n_nv - nv0, 0);
        bus_start(); send_byte(8'h5A, a); send_byte(8'hA2, a); bus_stop(); waitc(8);
        bus_start(); send_byte(8'h5A, a); send_byte(8'hC0, a);
        for (int i = 0; i < 4; i++) bus_bit(1'b1, r);
        bus_stop(); waitc(8);
        chk("R12 no strobe", n_valid - v0, 0);
        chk("R12 no nv", n_nv - nv0, 0);

        // R13: strobe width over the whole run
        chk("R13 single cycle", n_double, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule